// File: doc/BRIEF.md
# PLL Divider Reconfiguration and Lock Sequencer

This block is a hardware state machine that owns the control fields of a PLL and changes its divider settings safely. A rate request carries a new feedback divider M, pre-divider P, post-divider S and, in fractional builds, a fractional word K. The sequencer compares the requested M and P with the values the PLL runs on now. When they match, only the output-side fields (S, and K if present) are rewritten in place, with no disturbance to the loop. When they differ, the block walks the PLL through a safe relock. It holds the PLL in reset and routes the reference through bypass. It then loads the dividers and waits a minimum settle time before it releases reset. Last, it waits for lock, bounded by a timeout, and leaves bypass.

Two further commands power the PLL up (prepare) and down (unprepare). All delays are counted in clock cycles from parameters giving the clock frequency in MHz and the delays in microseconds. Outputs are the three register images, a prepared flag, a busy flag, a one-cycle done pulse and a timeout flag that pulses with done.

Top module: `pll_seq`

## Requirements
- R1: After reset every output is zero: general control, divider word 0, divider word 1, prepared, busy, done and timeout.
- R2: Field layout. In the general control word, bit 31 is the lock input registered once, bit 29 is lock-select, bit 9 is the active-low PLL reset and bit 4 is bypass. Divider word 0 holds M in bits 21:12, P in bits 9:4 and S in bits 2:0. Divider word 1 holds K in bits 15:0 when FRAC=1 and reads zero when FRAC=0.
- R3: A rate request whose M and P equal the current ones rewrites S (and K when FRAC=1) at the accepting edge. Done shows in the next cycle and busy never rises. Reset and bypass do not change.
- R4: A rate request with a different M or P raises busy. It then changes the fields in this order: lock-select set (FRAC=0 only), reset driven low, bypass set, dividers loaded, reset driven high.
- R5: Reset is released no sooner than SETTLE_US*CLK_MHZ cycles after the dividers are loaded.
- R6: When lock is seen after reset release, bypass clears and done pulses with timeout low.
- R7: If lock is not seen within LOCK_TMO_US*CLK_MHZ cycles of reset release, done pulses with timeout high, and bypass stays set.
- R8: Prepare with reset already high pulses done in the next cycle and changes nothing. Otherwise it sets bypass, drives reset high, waits for lock as in R6/R7 and clears bypass on lock.
- R9: Unprepare drives reset low at the accepting edge and pulses done in the next cycle.
- R10: The prepared output equals the reset bit of the general control word.
- R11: While busy, rate requests, prepare and unprepare are ignored.
- R12: Done is high for exactly one cycle per accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Rate change request (one-cycle pulse) |
| prep_i | input | 1 | Power-up command |
| unprep_i | input | 1 | Power-down command |
| m_i | input | MW | Requested feedback divider |
| p_i | input | PW | Requested pre-divider |
| s_i | input | SW | Requested post-divider |
| k_i | input | KW | Requested fractional word |
| lock_i | input | 1 | Lock indication from the PLL |
| gen_ctl_o | output | 32 | General control word image |
| div0_o | output | 32 | Divider word 0 image (M, P, S) |
| div1_o | output | 32 | Divider word 1 image (K) |
| prepared_o | output | 1 | PLL out of reset |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Lock timeout, pulses with done |

## Verification
The hardest situation to reach is a command arriving in the middle of a long relock, where it must be dropped. The stimulus pulses prepare and unprepare together a few cycles into a full sequence. It then checks that the PLL still ends out of reset with the new dividers. The lock-timeout path needs a PLL that never locks. The bench's PLL model has a switch that holds lock low, so the sequence runs to its timeout and bypass can be seen still set. Settle and timeout windows are measured by counting cycles between field changes seen at the ports.

// File: rtl/pll_seq_pkg.sv
`timescale 1ns/1ps
package pll_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LKSEL, ST_RSTLO, ST_BYPON, ST_LOAD, ST_SETTLE, ST_PRST, ST_WLOCK
  } seq_st_e;

  localparam int GBIT_LOCK  = 31;
  localparam int GBIT_LSEL  = 29;
  localparam int GBIT_RSTN  = 9;
  localparam int GBIT_BYP   = 4;
  localparam int DPOS_M     = 12;
  localparam int DPOS_P     = 4;
  localparam int DPOS_S     = 0;
endpackage

// File: rtl/pll_seq_timer.sv
`timescale 1ns/1ps
module pll_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (load)     cnt <= load_val;
    else if (dec && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/pll_seq_mpcmp.sv
`timescale 1ns/1ps
module pll_seq_mpcmp #(
  parameter int MW = 10,
  parameter int PW = 6
) (
  input  logic [MW-1:0] cur_m,
  input  logic [PW-1:0] cur_p,
  input  logic [MW-1:0] new_m,
  input  logic [PW-1:0] new_p,
  output logic          same
);
  assign same = (cur_m == new_m) && (cur_p == new_p);
endmodule

// File: rtl/pll_seq.sv
`timescale 1ns/1ps
module pll_seq
  import pll_seq_pkg::*;
#(
  parameter int CLK_MHZ     = 125,
  parameter int SETTLE_US   = 3,
  parameter int LOCK_TMO_US = 10000,
  parameter int FRAC        = 1,
  parameter int MW          = 10,
  parameter int PW          = 6,
  parameter int SW          = 3,
  parameter int KW          = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_i,
  input  logic          prep_i,
  input  logic          unprep_i,
  input  logic [MW-1:0] m_i,
  input  logic [PW-1:0] p_i,
  input  logic [SW-1:0] s_i,
  input  logic [KW-1:0] k_i,
  input  logic          lock_i,
  output logic [31:0]   gen_ctl_o,
  output logic [31:0]   div0_o,
  output logic [31:0]   div1_o,
  output logic          prepared_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          timeout_o
);
  localparam int SETTLE_CYC = SETTLE_US * CLK_MHZ;
  localparam int TMO_CYC    = LOCK_TMO_US * CLK_MHZ;
  localparam int MAX_CYC    = (SETTLE_CYC > TMO_CYC) ? SETTLE_CYC : TMO_CYC;
  localparam int CNT_W      = $clog2(MAX_CYC + 1);

  seq_st_e state;
  logic [MW-1:0] m_r, m_n;
  logic [PW-1:0] p_r, p_n;
  logic [SW-1:0] s_r, s_n;
  logic [KW-1:0] k_r, k_n;
  logic rst_n_r, byp_r, lsel_r, lock_r;
  logic mp_same, tmr_zero, tmr_load, tmr_dec;
  logic [CNT_W-1:0] tmr_val;

  pll_seq_mpcmp #(.MW(MW), .PW(PW)) cmp_i (
    .cur_m(m_r), .cur_p(p_r), .new_m(m_i), .new_p(p_i), .same(mp_same)
  );

  pll_seq_timer #(.W(CNT_W)) tmr_i (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
    .dec(tmr_dec), .zero(tmr_zero)
  );

  always_comb begin
    tmr_load = 1'b0;
    tmr_dec  = 1'b0;
    tmr_val  = '0;
    case (state)
      ST_LOAD: begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(SETTLE_CYC - 1);
      end
      ST_SETTLE: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(TMO_CYC - 1);
        end else begin
          tmr_dec = 1'b1;
        end
      end
      ST_PRST: begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(TMO_CYC - 1);
      end
      ST_WLOCK: tmr_dec = !lock_i;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      m_r <= '0; p_r <= '0; s_r <= '0; k_r <= '0;
      m_n <= '0; p_n <= '0; s_n <= '0; k_n <= '0;
      rst_n_r <= 1'b0;
      byp_r   <= 1'b0;
      lsel_r  <= 1'b0;
      lock_r  <= 1'b0;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
      lock_r    <= lock_i;
      case (state)
        ST_IDLE: begin
          if (req_i) begin
            if (mp_same) begin
              s_r    <= s_i;
              k_r    <= k_i;
              done_o <= 1'b1;
            end else begin
              m_n <= m_i; p_n <= p_i; s_n <= s_i; k_n <= k_i;
              busy_o <= 1'b1;
              state  <= (FRAC == 0) ? ST_LKSEL : ST_RSTLO;
            end
          end else if (prep_i) begin
            if (rst_n_r) begin
              done_o <= 1'b1;
            end else begin
              byp_r  <= 1'b1;
              busy_o <= 1'b1;
              state  <= ST_PRST;
            end
          end else if (unprep_i) begin
            rst_n_r <= 1'b0;
            done_o  <= 1'b1;
          end
        end
        ST_LKSEL: begin lsel_r <= 1'b1;  state <= ST_RSTLO; end
        ST_RSTLO: begin rst_n_r <= 1'b0; state <= ST_BYPON; end
        ST_BYPON: begin byp_r <= 1'b1;   state <= ST_LOAD;  end
        ST_LOAD: begin
          m_r <= m_n; p_r <= p_n; s_r <= s_n; k_r <= k_n;
          state <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (tmr_zero) begin
            rst_n_r <= 1'b1;
            state   <= ST_WLOCK;
          end
        end
        ST_PRST: begin rst_n_r <= 1'b1; state <= ST_WLOCK; end
        ST_WLOCK: begin
          if (lock_i) begin
            byp_r  <= 1'b0;
            done_o <= 1'b1;
            busy_o <= 1'b0;
            state  <= ST_IDLE;
          end else if (tmr_zero) begin
            timeout_o <= 1'b1;
            done_o    <= 1'b1;
            busy_o    <= 1'b0;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    gen_ctl_o = '0;
    gen_ctl_o[GBIT_LOCK] = lock_r;
    gen_ctl_o[GBIT_LSEL] = lsel_r;
    gen_ctl_o[GBIT_RSTN] = rst_n_r;
    gen_ctl_o[GBIT_BYP]  = byp_r;
    div0_o = '0;
    div0_o[DPOS_M +: MW] = m_r;
    div0_o[DPOS_P +: PW] = p_r;
    div0_o[DPOS_S +: SW] = s_r;
  end

  generate
    if (FRAC != 0) begin : g_frac
      always_comb begin
        div1_o = '0;
        div1_o[KW-1:0] = k_r;
      end
    end else begin : g_int
      assign div1_o = {32'b0, k_r[0] & 1'b0};
    end
  endgenerate

  assign prepared_o = rst_n_r;

  // Checker state for the settle window (R5)
  logic [CNT_W-1:0] chk_gap;
  logic             chk_arm;
  always_ff @(posedge clk) begin
    if (rst) begin
      chk_gap <= '0;
      chk_arm <= 1'b0;
    end else if (state == ST_LOAD) begin
      chk_gap <= '0;
      chk_arm <= 1'b1;
    end else begin
      if (chk_gap != {CNT_W{1'b1}}) chk_gap <= chk_gap + 1'b1;
      if (rst_n_r) chk_arm <= 1'b0;
    end
  end

  a_r5_settle_window: assert property (@(posedge clk) disable iff (rst)
    ($rose(rst_n_r) && chk_arm) |-> (chk_gap >= CNT_W'(SETTLE_CYC)));

  a_r7_bypass_kept_on_timeout: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> (byp_r && done_o));

  a_r12_done_when_idle: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  a_r3_fast_path_quiet: assert property (@(posedge clk) disable iff (rst)
    (req_i && !busy_o && mp_same) |=> ($stable(rst_n_r) && $stable(byp_r) && !busy_o));

  a_r4_bypass_during_lock_wait: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WLOCK) |-> byp_r);

  a_r11_no_restart_while_busy: assert property (@(posedge clk) disable iff (rst)
    (busy_o && state != ST_WLOCK) |=> busy_o);
endmodule

// File: tb/pll_seq_tb_top.sv
`timescale 1ns/1ps
module pll_seq_tb_top;
  localparam int MW = 10, PW = 6, SW = 3, KW = 16;
  localparam int CLK_MHZ = 125, SETTLE_US = 3, TMO_US = 4;
  localparam int SETTLE_CYC = SETTLE_US * CLK_MHZ;
  localparam int TMO_CYC = TMO_US * CLK_MHZ;
  localparam int LOCK_DLY = 40;

  logic clk = 0, rst = 1;
  logic req_i = 0, prep_i = 0, unprep_i = 0;
  logic [MW-1:0] m_i = '0;
  logic [PW-1:0] p_i = '0;
  logic [SW-1:0] s_i = '0;
  logic [KW-1:0] k_i = '0;
  logic lock_a, lock_b, dead = 0;
  logic [31:0] gen_a, div0_a, div1_a, gen_b, div0_b, div1_b;
  logic prep_a, busy_a, done_a_o, tmo_a_o, prep_b, busy_b, done_b_o, tmo_b_o;
  int lcnt_a = 0, lcnt_b = 0;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pll_seq #(.CLK_MHZ(CLK_MHZ), .SETTLE_US(SETTLE_US), .LOCK_TMO_US(TMO_US), .FRAC(0))
  dut_i (.clk(clk), .rst(rst), .req_i(req_i), .prep_i(prep_i), .unprep_i(unprep_i),
    .m_i(m_i), .p_i(p_i), .s_i(s_i), .k_i(k_i), .lock_i(lock_a),
    .gen_ctl_o(gen_a), .div0_o(div0_a), .div1_o(div1_a), .prepared_o(prep_a),
    .busy_o(busy_a), .done_o(done_a_o), .timeout_o(tmo_a_o));

  pll_seq #(.CLK_MHZ(CLK_MHZ), .SETTLE_US(SETTLE_US), .LOCK_TMO_US(TMO_US), .FRAC(1))
  dut_frac_i (.clk(clk), .rst(rst), .req_i(req_i), .prep_i(prep_i), .unprep_i(unprep_i),
    .m_i(m_i), .p_i(p_i), .s_i(s_i), .k_i(k_i), .lock_i(lock_b),
    .gen_ctl_o(gen_b), .div0_o(div0_b), .div1_o(div1_b), .prepared_o(prep_b),
    .busy_o(busy_b), .done_o(done_b_o), .timeout_o(tmo_b_o));

  // PLL models: lock some cycles after reset goes high, unless held dead
  always @(posedge clk) begin
    lcnt_a <= gen_a[9] ? ((lcnt_a < 1000) ? lcnt_a + 1 : lcnt_a) : 0;
    lcnt_b <= gen_b[9] ? ((lcnt_b < 1000) ? lcnt_b + 1 : lcnt_b) : 0;
  end
  assign lock_a = gen_a[9] && (lcnt_a >= LOCK_DLY) && !dead;
  assign lock_b = gen_b[9] && (lcnt_b >= LOCK_DLY) && !dead;

  function automatic logic [31:0] pack0(int m, int p, int s);
    return 32'(m * 4096 + p * 16 + s);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int t_lsel, t_rlo, t_byp, t_div, t_rst, t_done, n_done_a, n_done_b;
  bit busy_seen, tmo_a, tmo_b;

  task automatic run(input bit rq, input bit pp, input bit up,
                     input int m, input int p, input int s, input int k, input bit poke);
    logic [31:0] prev_div;
    logic prev_rn;
    int post;
    t_lsel = -1; t_rlo = -1; t_byp = -1; t_div = -1; t_rst = -1; t_done = -1;
    n_done_a = 0; n_done_b = 0; busy_seen = 0; tmo_a = 0; tmo_b = 0;
    @(negedge clk);
    req_i = rq; prep_i = pp; unprep_i = up;
    m_i = MW'(m); p_i = PW'(p); s_i = SW'(s); k_i = KW'(k);
    prev_div = div0_a; prev_rn = gen_a[9];
    @(negedge clk);
    req_i = 0; prep_i = 0; unprep_i = 0;
    post = 0;
    for (int i = 1; i < 5000; i++) begin
      if (poke && i == 10) begin prep_i = 1; unprep_i = 1; end
      else if (poke && i == 11) begin prep_i = 0; unprep_i = 0; end
      if (gen_a[29] && t_lsel < 0) t_lsel = i;
      if (!gen_a[9] && prev_rn && t_rlo < 0) t_rlo = i;
      if (gen_a[9] && !prev_rn && t_rst < 0) t_rst = i;
      if (gen_a[4] && t_byp < 0) t_byp = i;
      if (div0_a != prev_div && t_div < 0) t_div = i;
      prev_rn = gen_a[9]; prev_div = div0_a;
      if (busy_a || busy_b) busy_seen = 1;
      if (done_a_o) begin n_done_a++; if (t_done < 0) t_done = i; tmo_a = tmo_a_o; end
      if (done_b_o) begin n_done_b++; tmo_b = tmo_b_o; end
      if (n_done_a > 0 && n_done_b > 0) post++;
      if (post > 2) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(gen_a == 0 && gen_b == 0, "R1 gen_ctl", gen_a, 0);
    chk(div0_a == 0 && div1_b == 0, "R1 dividers", div0_a, 0);
    chk(!busy_a && !done_a_o && !tmo_a_o && !prep_a, "R1 flags", busy_a, 0);

    // R8 prepare from power-down
    run(0, 1, 0, 0, 0, 0, 0, 0);
    chk(t_byp > 0, "R8 bypass during prepare", t_byp, 1);
    chk(gen_a[9] == 1 && gen_a[4] == 0, "R8 reset high bypass clear", gen_a[9:4], 6'h20);
    chk(prep_a == 1 && prep_b == 1, "R10 prepared after prepare", prep_a, 1);
    chk(gen_a[31] == 1, "R2 lock status bit", gen_a[31], 1);
    chk(n_done_a == 1 && n_done_b == 1, "R12 done one cycle", n_done_a, 1);
    chk(!tmo_a && !tmo_b, "R6 no timeout on lock", tmo_a, 0);

    // R8 prepare when already prepared
    run(0, 1, 0, 0, 0, 0, 0, 0);
    chk(t_done == 1, "R8 prepared again done next cycle", t_done, 1);
    chk(!busy_seen, "R8 prepared again no busy", busy_seen, 0);

    // R4 R5 R6 R11 full change with commands poked mid-sequence
    run(1, 0, 0, 100, 3, 1, 12345, 1);
    chk(t_lsel > 0 && t_lsel < t_rlo, "R4 lock-select before reset low", t_lsel, t_rlo);
    chk(t_rlo < t_byp && t_byp < t_div && t_div < t_rst, "R4 order bypass-load-release",
        t_div, t_rst);
    chk(t_rst - t_div >= SETTLE_CYC, "R5 settle window", t_rst - t_div, SETTLE_CYC);
    chk(busy_seen, "R4 busy during sequence", busy_seen, 1);
    chk(div0_a == pack0(100, 3, 1), "R2 div0 packing", div0_a, pack0(100, 3, 1));
    chk(div1_b == 32'd12345 && div1_a == 0, "R2 div1 frac and int", div1_b, 12345);
    chk(gen_b[29] == 0 && gen_a[29] == 1, "R4 lock-select only integer", gen_b[29], 0);
    chk(gen_a[9] && gen_b[9], "R11 unprepare ignored while busy", gen_a[9], 1);
    chk(gen_a[4] == 0 && !tmo_a && n_done_a == 1, "R6 bypass cleared on lock", gen_a[4], 0);

    // R3 fast path sweep over every post-divider value
    for (int s = 0; s < 8; s++) begin
      run(1, 0, 0, 100, 3, s, s * 1000 + 7, 0);
      chk(t_done == 1 && !busy_seen, "R3 fast done no busy", t_done, 1);
      chk(t_rlo < 0 && t_byp < 0, "R3 no reset or bypass", t_byp, -1);
      chk(div0_a == pack0(100, 3, s), "R3 S rewritten", div0_a, pack0(100, 3, s));
      chk(div1_b == 32'(s * 1000 + 7), "R3 K rewritten", div1_b, s * 1000 + 7);
    end

    // R4 full changes over corner divider values
    for (int j = 0; j < 3; j++) begin
      int mm, pp;
      mm = (j == 0) ? 64 : (j == 1) ? 200 : 1023;
      pp = (j == 0) ? 1 : (j == 1) ? 2 : 63;
      run(1, 0, 0, mm, pp, 7 - j, j, 0);
      chk(div0_a == pack0(mm, pp, 7 - j) && div0_b == div0_a, "R4 divider sweep",
          div0_a, pack0(mm, pp, 7 - j));
      chk(t_rlo > 0 && t_rst - t_div >= SETTLE_CYC, "R5 settle in sweep", t_rst - t_div, SETTLE_CYC);
    end

    // R7 lock timeout
    dead = 1;
    run(1, 0, 0, 300, 5, 2, 0, 0);
    chk(tmo_a && tmo_b, "R7 timeout flagged", tmo_a, 1);
    chk(t_done - t_rst >= TMO_CYC, "R7 timeout window", t_done - t_rst, TMO_CYC);
    chk(gen_a[4] == 1 && gen_b[4] == 1, "R7 bypass left set", gen_a[4], 1);
    dead = 0;

    // R9 unprepare
    run(0, 0, 1, 0, 0, 0, 0, 0);
    chk(t_done == 1 && gen_a[9] == 0, "R9 reset low", gen_a[9], 0);
    chk(prep_a == 0 && prep_b == 0, "R10 prepared low", prep_a, 0);

    // R8 prepare again after power-down
    run(0, 1, 0, 0, 0, 0, 0, 0);
    chk(gen_a[9] && !gen_a[4] && prep_a, "R8 power-up relock", gen_a[9:4], 6'h20);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule